// File: doc/BRIEF.md
# I2C Address Alias Remapper

This block sits on the target side of a local I2C bus inside a serial-link bridge. For each transaction whose 7-bit address has been captured, it decides where the transaction goes. It can go to the local register bank, to the link partner device at the far end of the link, or to a downstream target hanging off that partner. Otherwise it is dropped. Forwarded transactions carry a substituted physical address, so the local bus can reach remote devices through alias addresses of its own choosing.

A small configuration write port loads the identity fields and the mode bits. These are the local address override, the partner ID with its freeze bit, the partner alias, the target ID and alias, and the control bits: pass-through enable, pass-all and early acknowledge. While the link reports lock, the partner ID follows the value the link learned, unless software froze it.

The block also decides when the local bus sees an ACK or a NACK. Local hits are acknowledged in the decision cycle and misses are refused in that cycle. Forwarded transactions either wait for the remote response or, for writes under early acknowledge on a locked link, are acknowledged at once.

Top module: `i2c_alias_remap`

## Requirements
- R1: The local address is `strap_addr` while the local-select bit is 0. When it is 1, the programmed local address is used instead. Config field 0 sets the local address from data[7:1] and the select bit from data[0].
- R2: An address equal to the local address is decoded as kind 1 (local) in every mode. This has priority over all forwarding. It reports `fwd_addr` = 0 and gives `ack_pulse` in the decision cycle. The decision outputs appear one clock after `txn_valid` is sampled.
- R3: An address equal to the partner alias is decoded as kind 2 (partner), with `fwd_addr` equal to the partner ID. Config field 1 sets the partner ID from data[7:1] and freeze from data[0]. Config field 2 sets the partner alias from data[7:1].
- R4: An address equal to the target alias is decoded as kind 3 (target), with `fwd_addr` equal to the target ID. If the two aliases are equal, the partner path wins. Config field 3 sets the target ID and config field 4 sets the target alias, each from data[7:1].
- R5: A path whose alias or ID is zero never matches. An address with no path is decoded as kind 0 (none), with `fwd_addr` = 0 and `nack_pulse` in the decision cycle.
- R6: With pass-through enable cleared, nothing is forwarded: every non-local address decodes as kind 0. Config field 5 holds pass-through enable in data[0] (reset 1), pass-all in data[1] and early acknowledge in data[2].
- R7: With pass-all set, a non-local address that matches no alias is forwarded as kind 2 to the partner ID, provided the partner ID is nonzero. With pass-all clear, such an address decodes as kind 0.
- R8: A forwarded write is acknowledged in the decision cycle when early acknowledge is set and `link_lock` is high.
- R9: A forwarded read, and any forwarded write not covered by R8, gives no pulse in the decision cycle. It gives `ack_pulse` or `nack_pulse`, as `rsp_ack` says, one clock after `rsp_valid` is sampled.
- R10: While `link_lock` is high and freeze is 0, the partner ID is loaded from `link_partner_id` every clock. With freeze set, the written value is kept.
- R11: After reset, `dec_valid`, `ack_pulse` and `nack_pulse` are 0, all IDs and aliases are 0, pass-through is enabled and the other mode bits are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_field | input | 3 | Configuration field select |
| cfg_data | input | 8 | Configuration write data |
| strap_addr | input | 7 | Strapped local address |
| link_lock | input | 1 | Serial link locked |
| link_partner_id | input | 7 | Partner ID learned over the link |
| txn_valid | input | 1 | Address of a new transaction is present |
| txn_addr | input | 7 | 7-bit transaction address |
| txn_rnw | input | 1 | 1 = read, 0 = write |
| rsp_valid | input | 1 | Remote response for the pending transaction |
| rsp_ack | input | 1 | Remote response was an acknowledge |
| dec_valid | output | 1 | Decision outputs updated this cycle |
| dec_kind | output | 2 | 0 none, 1 local, 2 partner, 3 target |
| fwd_addr | output | 7 | Remapped address for forwarding, 0 if not forwarded |
| ack_pulse | output | 1 | Acknowledge the local bus |
| nack_pulse | output | 1 | Refuse the local bus |

## Verification
The hardest case to reach is the partner ID being overwritten by the link, or kept by freeze, while an early-acknowledged write is in flight. It needs lock, a learned ID, a frozen or unfrozen field and auto-acknowledge all lined up at once. The bench first programs a frozen partner ID and raises lock with a different learned ID, then sends writes and reads through the partner alias. It then clears freeze and sends again. The remapped address on `fwd_addr` shows which ID won, and the pulse timing shows whether the acknowledge was early or waited for `rsp_valid`.

// File: rtl/iar_pkg.sv
package iar_pkg;
    localparam int ADDR_W  = 7;
    localparam int FIELD_W = 3;
    localparam int DATA_W  = ADDR_W + 1;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        KIND_NONE    = 2'd0,
        KIND_LOCAL   = 2'd1,
        KIND_PARTNER = 2'd2,
        KIND_TARGET  = 2'd3
    } kind_e;

    typedef enum logic [FIELD_W-1:0] {
        FLD_LOCAL   = 3'd0,
        FLD_PID     = 3'd1,
        FLD_PALIAS  = 3'd2,
        FLD_TID     = 3'd3,
        FLD_TALIAS  = 3'd4,
        FLD_CTRL    = 3'd5
    } field_e;

    typedef struct packed {
        addr_t local_addr;
        logic  local_sel;
        addr_t partner_id;
        logic  freeze;
        addr_t partner_alias;
        addr_t target_id;
        addr_t target_alias;
        logic  pass_en;
        logic  pass_all;
        logic  auto_ack;
    } cfg_t;

    // A path is live only when both its alias and its physical ID are nonzero.
    function automatic logic path_hit(addr_t a, addr_t alias_v, addr_t id_v);
        return (alias_v != '0) && (id_v != '0) && (a == alias_v);
    endfunction

    function automatic logic is_fwd(kind_e k);
        return (k == KIND_PARTNER) || (k == KIND_TARGET);
    endfunction
endpackage

// File: rtl/iar_cfg_regs.sv
module iar_cfg_regs
    import iar_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr,
    input  logic [FIELD_W-1:0] cfg_field,
    input  logic [DATA_W-1:0]  cfg_data,
    input  logic               link_lock,
    input  addr_t              link_partner_id,
    output cfg_t               cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg          <= '0;
            cfg.pass_en  <= 1'b1;
        end else begin
            if (link_lock && !cfg.freeze)
                cfg.partner_id <= link_partner_id;
            if (cfg_wr) begin
                case (field_e'(cfg_field))
                    FLD_LOCAL: begin
                        cfg.local_addr <= cfg_data[DATA_W-1:1];
                        cfg.local_sel  <= cfg_data[0];
                    end
                    FLD_PID: begin
                        cfg.partner_id <= cfg_data[DATA_W-1:1];
                        cfg.freeze     <= cfg_data[0];
                    end
                    FLD_PALIAS: cfg.partner_alias <= cfg_data[DATA_W-1:1];
                    FLD_TID:    cfg.target_id     <= cfg_data[DATA_W-1:1];
                    FLD_TALIAS: cfg.target_alias  <= cfg_data[DATA_W-1:1];
                    FLD_CTRL: begin
                        cfg.pass_en  <= cfg_data[0];
                        cfg.pass_all <= cfg_data[1];
                        cfg.auto_ack <= cfg_data[2];
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/iar_decode.sv
module iar_decode
    import iar_pkg::*;
(
    input  cfg_t  cfg,
    input  addr_t strap_addr,
    input  addr_t addr,
    output addr_t local_eff,
    output kind_e kind,
    output addr_t fwd
);
    always_comb begin
        local_eff = cfg.local_sel ? cfg.local_addr : strap_addr;
        kind      = KIND_NONE;
        fwd       = '0;
        if (addr == local_eff) begin
            kind = KIND_LOCAL;
        end else if (cfg.pass_en) begin
            if (path_hit(addr, cfg.partner_alias, cfg.partner_id)) begin
                kind = KIND_PARTNER;
                fwd  = cfg.partner_id;
            end else if (path_hit(addr, cfg.target_alias, cfg.target_id)) begin
                kind = KIND_TARGET;
                fwd  = cfg.target_id;
            end else if (cfg.pass_all && (cfg.partner_id != '0)) begin
                kind = KIND_PARTNER;
                fwd  = cfg.partner_id;
            end
        end
    end
endmodule

// File: rtl/iar_ack_ctrl.sv
module iar_ack_ctrl
    import iar_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  txn_valid,
    input  logic  txn_rnw,
    input  kind_e kind,
    input  addr_t fwd,
    input  logic  early_ok,
    input  logic  rsp_valid,
    input  logic  rsp_ack,
    output logic  dec_valid,
    output kind_e dec_kind,
    output addr_t fwd_addr,
    output logic  ack_pulse,
    output logic  nack_pulse,
    output logic  pending
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid  <= 1'b0;
            dec_kind   <= KIND_NONE;
            fwd_addr   <= '0;
            ack_pulse  <= 1'b0;
            nack_pulse <= 1'b0;
            pending    <= 1'b0;
        end else begin
            dec_valid  <= txn_valid;
            ack_pulse  <= 1'b0;
            nack_pulse <= 1'b0;
            if (txn_valid) begin
                dec_kind <= kind;
                fwd_addr <= fwd;
                pending  <= 1'b0;
                if (kind == KIND_NONE)
                    nack_pulse <= 1'b1;
                else if (kind == KIND_LOCAL)
                    ack_pulse <= 1'b1;
                else if (!txn_rnw && early_ok)
                    ack_pulse <= 1'b1;
                else
                    pending <= 1'b1;
            end else if (pending && rsp_valid) begin
                pending    <= 1'b0;
                ack_pulse  <= rsp_ack;
                nack_pulse <= !rsp_ack;
            end
        end
    end
endmodule

// File: rtl/i2c_alias_remap.sv
module i2c_alias_remap
    import iar_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wr,
    input  logic [2:0] cfg_field,
    input  logic [7:0] cfg_data,
    input  logic [6:0] strap_addr,
    input  logic       link_lock,
    input  logic [6:0] link_partner_id,
    input  logic       txn_valid,
    input  logic [6:0] txn_addr,
    input  logic       txn_rnw,
    input  logic       rsp_valid,
    input  logic       rsp_ack,
    output logic       dec_valid,
    output logic [1:0] dec_kind,
    output logic [6:0] fwd_addr,
    output logic       ack_pulse,
    output logic       nack_pulse
);
    cfg_t  cfg;
    addr_t local_eff;
    kind_e kind_c;
    kind_e kind_q;
    addr_t fwd_c;
    logic  pending;

    iar_cfg_regs u_regs (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_field(cfg_field),
        .cfg_data(cfg_data), .link_lock(link_lock),
        .link_partner_id(link_partner_id), .cfg(cfg)
    );

    iar_decode u_dec (
        .cfg(cfg), .strap_addr(strap_addr), .addr(txn_addr),
        .local_eff(local_eff), .kind(kind_c), .fwd(fwd_c)
    );

    iar_ack_ctrl u_ack (
        .clk(clk), .rst(rst), .txn_valid(txn_valid), .txn_rnw(txn_rnw),
        .kind(kind_c), .fwd(fwd_c), .early_ok(cfg.auto_ack && link_lock),
        .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .dec_valid(dec_valid),
        .dec_kind(kind_q), .fwd_addr(fwd_addr), .ack_pulse(ack_pulse),
        .nack_pulse(nack_pulse), .pending(pending)
    );

    assign dec_kind = kind_q;
endmodule

// File: rtl/i2c_alias_remap_chk.sv
module i2c_alias_remap_chk
    import iar_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       txn_valid,
    input logic [6:0] txn_addr,
    input logic       txn_rnw,
    input logic       link_lock,
    input logic       cfg_wr,
    input cfg_t       cfg,
    input addr_t      local_eff,
    input kind_e      kind_c,
    input logic       dec_valid,
    input logic [1:0] dec_kind,
    input logic [6:0] fwd_addr,
    input logic       ack_pulse,
    input logic       nack_pulse
);
    AST_LOCAL_FIRST: assert property (@(posedge clk) disable iff (rst)
        txn_valid && (txn_addr == local_eff) |=> (dec_kind == 2'd1) && ack_pulse); // R2
    AST_FWD_NONZERO: assert property (@(posedge clk) disable iff (rst)
        dec_valid && dec_kind[1] |-> (fwd_addr != 7'd0)); // R5
    AST_GATE_OFF: assert property (@(posedge clk) disable iff (rst)
        txn_valid && !cfg.pass_en && (txn_addr != local_eff) |=> (dec_kind == 2'd0) && nack_pulse); // R6
    AST_EARLY_ACK: assert property (@(posedge clk) disable iff (rst)
        txn_valid && !txn_rnw && is_fwd(kind_c) && cfg.auto_ack && link_lock |=> ack_pulse); // R8
    AST_READ_WAITS: assert property (@(posedge clk) disable iff (rst)
        txn_valid && txn_rnw && is_fwd(kind_c) |=> !ack_pulse && !nack_pulse); // R9
    AST_FROZEN_ID: assert property (@(posedge clk) disable iff (rst)
        cfg.freeze && !cfg_wr |=> $stable(cfg.partner_id)); // R10
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ack_pulse && nack_pulse)); // R9
endmodule

bind i2c_alias_remap i2c_alias_remap_chk u_chk (
    .clk(clk), .rst(rst), .txn_valid(txn_valid), .txn_addr(txn_addr),
    .txn_rnw(txn_rnw), .link_lock(link_lock), .cfg_wr(cfg_wr), .cfg(cfg),
    .local_eff(local_eff), .kind_c(kind_c), .dec_valid(dec_valid),
    .dec_kind(dec_kind), .fwd_addr(fwd_addr), .ack_pulse(ack_pulse),
    .nack_pulse(nack_pulse)
);

// File: tb/i2c_alias_remap_bench.sv
module i2c_alias_remap_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_field = '0;
    logic [7:0] cfg_data = '0;
    logic [6:0] strap_addr = 7'h2A;
    logic       link_lock = 1'b0;
    logic [6:0] link_partner_id = '0;
    logic       txn_valid = 1'b0;
    logic [6:0] txn_addr = '0;
    logic       txn_rnw = 1'b0;
    logic       rsp_valid = 1'b0;
    logic       rsp_ack = 1'b0;
    logic       dec_valid;
    logic [1:0] dec_kind;
    logic [6:0] fwd_addr;
    logic       ack_pulse;
    logic       nack_pulse;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    i2c_alias_remap u_i2c_alias_remap (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_field(cfg_field),
        .cfg_data(cfg_data), .strap_addr(strap_addr), .link_lock(link_lock),
        .link_partner_id(link_partner_id), .txn_valid(txn_valid),
        .txn_addr(txn_addr), .txn_rnw(txn_rnw), .rsp_valid(rsp_valid),
        .rsp_ack(rsp_ack), .dec_valid(dec_valid), .dec_kind(dec_kind),
        .fwd_addr(fwd_addr), .ack_pulse(ack_pulse), .nack_pulse(nack_pulse)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] f, input logic [6:0] v, input logic b0);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_field = f; cfg_data = {v, b0};
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Sends one address; wait_rsp: 0 = pulse in decision cycle, 1 = remote response needed.
    task automatic send(input string req, input logic [6:0] a, input logic rnw,
                        input int kind, input int fwd, input int wait_rsp, input logic rsp);
        @(negedge clk);
        txn_valid = 1'b1; txn_addr = a; txn_rnw = rnw;
        @(negedge clk);
        txn_valid = 1'b0;
        check({req, " valid"}, dec_valid, 1);
        check({req, " kind"}, dec_kind, kind);
        check({req, " fwd"}, fwd_addr, fwd);
        if (wait_rsp != 0) begin
            check({req, " no early pulse"}, {ack_pulse, nack_pulse}, 0);
            rsp_valid = 1'b1; rsp_ack = rsp;
            @(negedge clk);
            rsp_valid = 1'b0;
            check({req, " rsp pulse"}, {ack_pulse, nack_pulse}, rsp ? 2 : 1);
        end else begin
            check({req, " pulse"}, {ack_pulse, nack_pulse}, (kind == 0) ? 1 : 2);
        end
    endtask

    task automatic t_reset;
        check("R11 dec_valid", dec_valid, 0);
        check("R11 pulses", {ack_pulse, nack_pulse}, 0);
        send("R11 no ids", 7'h41, 1'b0, 0, 0, 0, 1'b0);
    endtask

    task automatic t_local;
        send("R1 strap local", 7'h2A, 1'b0, 1, 0, 0, 1'b0);
        cfg_write(3'd0, 7'h30, 1'b1);
        send("R1 strap ignored", 7'h2A, 1'b0, 0, 0, 0, 1'b0);
        send("R1 reg local", 7'h30, 1'b1, 1, 0, 0, 1'b0);
        cfg_write(3'd0, 7'h00, 1'b0);
    endtask

    task automatic t_partner_target;
        cfg_write(3'd1, 7'h60, 1'b0);
        cfg_write(3'd2, 7'h41, 1'b0);
        cfg_write(3'd3, 7'h22, 1'b0);
        cfg_write(3'd4, 7'h43, 1'b0);
        send("R3 partner alias", 7'h41, 1'b0, 2, 7'h60, 1, 1'b1);
        send("R4 target alias", 7'h43, 1'b1, 3, 7'h22, 1, 1'b0);
        send("R7 no pass_all", 7'h55, 1'b0, 0, 0, 0, 1'b0);
        cfg_write(3'd4, 7'h41, 1'b0);
        send("R4 partner wins", 7'h41, 1'b0, 2, 7'h60, 1, 1'b1);
        cfg_write(3'd4, 7'h43, 1'b0);
        send("R2 local over alias", 7'h2A, 1'b0, 1, 0, 0, 1'b0);
    endtask

    task automatic t_zero;
        cfg_write(3'd3, 7'h00, 1'b0);
        send("R5 zero target id", 7'h43, 1'b0, 0, 0, 0, 1'b0);
        cfg_write(3'd3, 7'h22, 1'b0);
        cfg_write(3'd2, 7'h00, 1'b0);
        send("R5 zero partner alias", 7'h00, 1'b0, 0, 0, 0, 1'b0);
        cfg_write(3'd2, 7'h41, 1'b0);
    endtask

    task automatic t_pass;
        cfg_write(3'd5, 7'h01, 1'b1);   // pass_en=1, pass_all=1
        send("R7 pass_all remap", 7'h55, 1'b0, 2, 7'h60, 1, 1'b1);
        send("R7 pass_all local", 7'h2A, 1'b0, 1, 0, 0, 1'b0);
        cfg_write(3'd1, 7'h00, 1'b0);
        send("R7 pass_all zero id", 7'h55, 1'b0, 0, 0, 0, 1'b0);
        cfg_write(3'd1, 7'h60, 1'b0);
        cfg_write(3'd5, 7'h00, 1'b0);   // all control clear
        send("R6 gate off alias", 7'h41, 1'b0, 0, 0, 0, 1'b0);
        send("R6 gate off local", 7'h2A, 1'b0, 1, 0, 0, 1'b0);
    endtask

    task automatic t_early;
        cfg_write(3'd5, 7'h02, 1'b1);   // pass_en=1, auto_ack=1
        cfg_write(3'd1, 7'h60, 1'b1);   // frozen
        @(negedge clk);
        link_partner_id = 7'h11; link_lock = 1'b1;
        repeat (2) @(negedge clk);
        send("R8 early write", 7'h41, 1'b0, 2, 7'h60, 0, 1'b0);
        send("R9 read waits", 7'h41, 1'b1, 2, 7'h60, 1, 1'b0);
        link_lock = 1'b0;
        send("R9 no lock waits", 7'h41, 1'b0, 2, 7'h60, 1, 1'b1);
    endtask

    task automatic t_autoload;
        cfg_write(3'd1, 7'h60, 1'b0);
        @(negedge clk);
        link_lock = 1'b1; link_partner_id = 7'h11;
        repeat (2) @(negedge clk);
        link_lock = 1'b0; link_partner_id = 7'h12;
        repeat (2) @(negedge clk);
        send("R10 autoload", 7'h41, 1'b0, 2, 7'h11, 1, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_local();
        t_partner_target();
        t_zero();
        t_pass();
        t_early();
        t_autoload();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule